// File: doc/BRIEF.md
# Configuration Loader with Daisy-Chain Overflow

This block is the front end that receives the configuration stream of a programmable device. A three-bit mode input selects one of two ways to take in data. In serial mode, one bit from a data pin is taken on every rising edge of the configuration clock. In parallel mode, a byte is taken on each clock edge while an active-low write strobe and two active-low chip selects are all low. Every accepted bit adds one to an internal count and every accepted byte adds eight. When the count reaches the configured length, the completion flag rises and stays high until reset.

After completion the block can act as a link in a chain of devices. In serial bypass, later serial input is passed straight to the serial output. In parallel bypass, later bytes are shifted out serially, most significant bit first, and a ready output holds off the next byte until the shift is over. In flow-through, an active-low chip-select output is asserted so that the next parallel device is enabled. A change on either chip-select input ends any of these modes.

Top module: `cfgl_top`

## Requirements
- R1: `mode_sel` decodes as 3'b000 serial, 3'b001 serial bypass, 3'b100 parallel, 3'b101 parallel bypass and 3'b110 parallel flow-through. Every other code acts as serial.
- R2: In the serial modes, one bit is counted on every rising clock edge after reset. `done` reads 1 after exactly CFG_BITS edges and 0 after CFG_BITS-1 edges.
- R3: In the parallel modes, a byte is counted as 8 bits only on an edge where `wr_n`, `cs_a_n` and `cs_b_n` are all 0. `done` rises after the edge that takes byte CFG_BITS/8.
- R4: Once `done` is 1, it stays 1 until reset, whatever data arrives later.
- R5: In serial bypass after completion, `ser_dout` equals the `ser_din` value sampled on the previous edge.
- R6: In parallel bypass after completion, a byte is taken on an edge where `wr_n` is 0 and `par_ready` is 1. On each of the next 8 edges it moves one bit to `ser_dout`, bit 7 first. `par_ready` stays 0 until the last bit is out, so a byte offered during the shift is not taken.
- R7: In flow-through, `cs_out_n` goes to 0 one edge after the edge on which `done` rises.
- R8: While an overflow mode is active, a change of level on `cs_a_n` or `cs_b_n` ends it. From then on, `ser_dout` idles at 1, `par_ready` is 0 and `cs_out_n` returns to 1 within two edges.
- R9: A synchronous reset clears `done` to 0 and sets `cs_out_n` and `ser_dout` to 1. Afterwards, `par_ready` is 1 in the parallel modes and 0 in the serial modes.
- R10: In a mode without overflow, `ser_dout` and `cs_out_n` stay at 1 after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; every action happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Load and overflow mode code |
| ser_din | input | 1 | Serial configuration data |
| par_data | input | 8 | Parallel configuration byte |
| cs_a_n | input | 1 | First active-low chip select |
| cs_b_n | input | 1 | Second active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| done | output | 1 | Configuration length reached (sticky) |
| ser_dout | output | 1 | Serial stream to the downstream device, idle 1 |
| cs_out_n | output | 1 | Active-low enable to the next parallel device |
| par_ready | output | 1 | A byte can be accepted this cycle |

## Verification
A count that is off by one shows as `done` rising one edge early or one edge late. The bench therefore samples `done` just before and just after the expected edge. A wrong overflow state shows within one or two edges: `cs_out_n` low without cause, serial data forwarded when it should not be, or missing forwarded data. A fault in the shift counter shows in the bit order on `ser_dout`, or as a byte taken during a shift, which corrupts the next eight bits. The bench compares every bit position against a value it computes on its own.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    MD_SER      = 3'b000,
    MD_SER_BYP  = 3'b001,
    MD_PAR      = 3'b100,
    MD_PAR_BYP  = 3'b101,
    MD_PAR_FLOW = 3'b110
  } cfgl_mode_e;

  function automatic cfgl_mode_e cfgl_decode(input logic [2:0] code);
    case (code)
      3'b001:  return MD_SER_BYP;
      3'b100:  return MD_PAR;
      3'b101:  return MD_PAR_BYP;
      3'b110:  return MD_PAR_FLOW;
      default: return MD_SER;
    endcase
  endfunction

  function automatic logic cfgl_is_par(input cfgl_mode_e m);
    return (m == MD_PAR) || (m == MD_PAR_BYP) || (m == MD_PAR_FLOW);
  endfunction

  function automatic logic cfgl_has_ovf(input cfgl_mode_e m);
    return (m == MD_SER_BYP) || (m == MD_PAR_BYP) || (m == MD_PAR_FLOW);
  endfunction
endpackage

// File: rtl/cfgl_loader.sv
module cfgl_loader
  import cfgl_pkg::*;
#(
  parameter int CFG_BITS = 32,
  parameter int BYTE_W   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  cfgl_mode_e mode,
  input  logic       wr_n,
  input  logic       cs_a_n,
  input  logic       cs_b_n,
  output logic       done_o,
  output logic       fin_o
);
  localparam int CW = $clog2(CFG_BITS + BYTE_W + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] step;
  logic [CW-1:0] cnt_sum;
  logic          take;
  logic          par_mode;

  assign par_mode = cfgl_is_par(mode);
  assign step     = par_mode ? CW'(BYTE_W) : CW'(1);
  assign take     = !done_o && (par_mode ? (!wr_n && !cs_a_n && !cs_b_n) : 1'b1);
  assign cnt_sum  = cnt_q + step;
  assign fin_o    = take && (cnt_sum >= CW'(CFG_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_sum;
      if (fin_o) done_o <= 1'b1;
    end
  end

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> done_o);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(CFG_BITS));
  // R3
  par_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (par_mode && !done_o && wr_n) |=> $stable(cnt_q));
endmodule

// File: rtl/cfgl_overflow.sv
module cfgl_overflow
  import cfgl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cfgl_mode_e mode,
  input  logic       fin_i,
  input  logic       done_i,
  input  logic       cs_a_n,
  input  logic       cs_b_n,
  output logic       ovf_o,
  output logic       cs_out_n
);
  logic cs_a_q, cs_b_q;
  logic toggle;

  assign toggle = (cs_a_n != cs_a_q) || (cs_b_n != cs_b_q);

  always_ff @(posedge clk) begin
    cs_a_q <= cs_a_n;
    cs_b_q <= cs_b_n;
    if (rst) begin
      ovf_o    <= 1'b0;
      cs_out_n <= 1'b1;
    end else begin
      if (fin_i && cfgl_has_ovf(mode)) ovf_o <= 1'b1;
      else if (ovf_o && toggle)        ovf_o <= 1'b0;
      cs_out_n <= !(ovf_o && (mode == MD_PAR_FLOW));
    end
  end

  // R7
  csout_done_chk: assert property (@(posedge clk) disable iff (rst) !cs_out_n |-> done_i);
  // R8
  toggle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && toggle) |=> !ovf_o);
  // R4
  ovf_done_chk: assert property (@(posedge clk) disable iff (rst) ovf_o |-> done_i);
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer
  import cfgl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgl_mode_e        mode,
  input  logic              ovf_i,
  input  logic              done_i,
  input  logic              ser_din,
  input  logic [BYTE_W-1:0] par_data,
  input  logic              wr_n,
  output logic              ser_dout,
  output logic              ready_o
);
  localparam int RW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh_q;
  logic [RW-1:0]     rem_q;
  logic              pbyp;

  assign pbyp    = ovf_i && (mode == MD_PAR_BYP);
  assign ready_o = (cfgl_is_par(mode) && !done_i) || (pbyp && rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !ovf_i) begin
      sh_q     <= '0;
      rem_q    <= '0;
      ser_dout <= 1'b1;
    end else if (mode == MD_SER_BYP) begin
      ser_dout <= ser_din;
    end else if (pbyp && rem_q != '0) begin
      ser_dout <= sh_q[BYTE_W-1];
      sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
      rem_q    <= rem_q - RW'(1);
    end else begin
      ser_dout <= 1'b1;
      if (pbyp && !wr_n) begin
        sh_q  <= par_data;
        rem_q <= RW'(BYTE_W);
      end
    end
  end

  // R6
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst) rem_q <= RW'(BYTE_W));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_q != '0 && ovf_i) |-> !ready_o);
  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovf_i && !$past(ovf_i)) |-> ser_dout);
endmodule

// File: rtl/cfgl_top.sv
module cfgl_top
  import cfgl_pkg::*;
#(
  parameter int CFG_BITS = 32,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  input  logic              ser_din,
  input  logic [BYTE_W-1:0] par_data,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              wr_n,
  output logic              done,
  output logic              ser_dout,
  output logic              cs_out_n,
  output logic              par_ready
);
  cfgl_mode_e mode;
  logic       fin;
  logic       ovf;

  assign mode = cfgl_decode(mode_sel);

  cfgl_loader #(.CFG_BITS(CFG_BITS), .BYTE_W(BYTE_W)) u_load (
    .clk(clk), .rst(rst), .mode(mode), .wr_n(wr_n),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .done_o(done), .fin_o(fin)
  );

  cfgl_overflow u_ovf (
    .clk(clk), .rst(rst), .mode(mode), .fin_i(fin), .done_i(done),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .ovf_o(ovf), .cs_out_n(cs_out_n)
  );

  cfgl_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst(rst), .mode(mode), .ovf_i(ovf), .done_i(done),
    .ser_din(ser_din), .par_data(par_data), .wr_n(wr_n),
    .ser_dout(ser_dout), .ready_o(par_ready)
  );

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfgl_has_ovf(mode) && $stable(mode_sel)) |=> (cs_out_n && ser_dout));
  // R1
  serial_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgl_is_par(mode) |-> !par_ready);
endmodule

// File: tb/cfgl_top_tb.sv
module cfgl_top_tb_top;
  localparam int CFG_BITS = 32;
  localparam int NBYTES   = CFG_BITS / 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'b000;
  logic       ser_din = 1'b0;
  logic [7:0] par_data = 8'h00;
  logic       cs_a_n = 1'b0;
  logic       cs_b_n = 1'b0;
  logic       wr_n = 1'b1;
  logic       done, ser_dout, cs_out_n, par_ready;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgl_top #(.CFG_BITS(CFG_BITS), .BYTE_W(8)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_din(ser_din),
    .par_data(par_data), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
    .done(done), .ser_dout(ser_dout), .cs_out_n(cs_out_n), .par_ready(par_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    mode_sel = m; rst = 1'b1; wr_n = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0; ser_din = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d);
    par_data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic t_serial(input logic [2:0] m, input string tag);
    do_reset(m);
    chk({"R9 done after reset ", tag}, done, 0);
    chk({"R9 ready serial ", tag}, par_ready, 0);
    for (int i = 0; i < CFG_BITS - 1; i++) @(negedge clk);
    chk({"R2 done early ", tag}, done, 0);
    @(negedge clk);
    chk({"R2 done at length ", tag}, done, 1);
    for (int i = 0; i < 4; i++) begin
      ser_din = i[0];
      @(negedge clk);
      chk({"R10 dout idle ", tag}, ser_dout, 1);
      chk({"R10 csout idle ", tag}, cs_out_n, 1);
    end
    chk({"R4 done sticky ", tag}, done, 1);
  endtask

  task automatic t_ser_bypass();
    logic [7:0] pat = 8'b1011_0010;
    do_reset(3'b001);
    for (int i = 0; i < CFG_BITS; i++) @(negedge clk);
    chk("R2 done serial bypass", done, 1);
    for (int i = 7; i >= 0; i--) begin
      ser_din = pat[i];
      @(negedge clk);
      chk("R5 forwarded bit", ser_dout, pat[i]);
    end
    ser_din = 1'b0; cs_a_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 serial exit dout", ser_dout, 1);
    @(negedge clk);
    chk("R8 serial exit stays", ser_dout, 1);
  endtask

  task automatic t_parallel();
    do_reset(3'b100);
    chk("R9 ready parallel", par_ready, 1);
    chk("R9 csout reset", cs_out_n, 1);
    cs_b_n = 1'b1;
    for (int i = 0; i < NBYTES; i++) put_byte(8'h11);
    cs_b_n = 1'b0; cs_a_n = 1'b1;
    for (int i = 0; i < NBYTES; i++) put_byte(8'h22);
    cs_a_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no take without strobe or select", done, 0);
    for (int i = 0; i < NBYTES - 1; i++) put_byte(8'h33);
    chk("R3 done before last byte", done, 0);
    put_byte(8'h44);
    chk("R3 done after last byte", done, 1);
    chk("R3 ready drops", par_ready, 0);
    put_byte(8'h55);
    chk("R4 done stays", done, 1);
    chk("R10 par csout", cs_out_n, 1);
    chk("R10 par dout", ser_dout, 1);
  endtask

  task automatic t_par_bypass();
    logic [7:0] a = 8'hA5;
    logic [7:0] b = 8'h3C;
    do_reset(3'b101);
    for (int i = 0; i < NBYTES; i++) put_byte(8'h00);
    chk("R3 done bypass load", done, 1);
    chk("R6 ready after done", par_ready, 1);
    par_data = a; wr_n = 1'b0;
    @(negedge clk);
    par_data = b;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R6 msb first bit", ser_dout, a[8-k]);
      chk("R6 ready during shift", par_ready, (k == 8) ? 1 : 0);
    end
    @(negedge clk);
    wr_n = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R6 second byte bit", ser_dout, b[8-k]);
    end
    @(negedge clk);
    cs_b_n = 1'b1;
    @(negedge clk);
    chk("R8 ready after exit", par_ready, 0);
    put_byte(8'h00);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk("R8 no shift after exit", ser_dout, 1);
    end
  endtask

  task automatic t_flow();
    do_reset(3'b110);
    for (int i = 0; i < NBYTES; i++) put_byte(8'h00);
    chk("R7 done flow", done, 1);
    chk("R7 csout not yet", cs_out_n, 1);
    @(negedge clk);
    chk("R7 csout active", cs_out_n, 0);
    @(negedge clk);
    chk("R7 csout held", cs_out_n, 0);
    cs_a_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 csout released", cs_out_n, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset clears done", done, 0);
    chk("R9 reset csout", cs_out_n, 1);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_serial(3'b000, "R1 serial");
    t_serial(3'b011, "R1 unused code");
    t_serial(3'b111, "R1 unused code 7");
    t_ser_bypass();
    t_parallel();
    t_par_bypass();
    t_flow();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule